// File: doc/BRIEF.md
# Bit-Field Signed Extract and Clear-Insert Unit

This combinational unit executes two bit-field instructions on a 64-bit source operand. It takes a 32-bit instruction word and the value of the source register, and it returns the 64-bit result, the destination register index, a write-enable and a valid flag. Register file reads and writes, and every other instruction, belong to the surrounding pipeline.

The signed-extract operation takes a field of a given length from a given bit position of the source and sign-extends it to 64 bits. The clear-insert operation takes the low bits of the source, places them at the given position, and clears every other bit. The instruction word carries the field length as length minus one. It carries the bit position in two pieces, so that a single encoding bit selects the upper half of the word.

Top module: `bfx_unit`

## Requirements
- R1: Signed extract is selected when instr[31:26] = 6'b011100 and instr[5:1] = 5'b11101. result holds bits [pos+len-1:pos] of rs_val in its low len bits, and every higher bit is a copy of the top bit of that field.
- R2: Clear-insert is selected when instr[31:26] = 6'b011100 and instr[5:1] = 5'b11001. result holds bits [len-1:0] of rs_val at bits [pos+len-1:pos], and every other bit of result is zero.
- R3: The bit position pos is the 6-bit value {instr[0], instr[10:6]}, so an encoding with instr[0] = 1 addresses positions 32 to 63.
- R4: The field length len is instr[15:11] + 1, which gives a range of 1 to 32.
- R5: When pos+len exceeds 64, field bits above bit 63 are dropped. Clear-insert keeps only the bits that fall inside the word. Signed extract takes rs_val[63] as the sign bit and copies it into every bit above the truncated field.
- R6: dst_idx always equals instr[20:16]. wr_en is high exactly when valid is high and dst_idx is non-zero, so a destination of 0 is a no-op.
- R7: Any encoding that is not one of the two recognized ones drives valid low, wr_en low and result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rs_val | input | 64 | Source operand value |
| result | output | 64 | Computed result |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write-enable for the destination register |
| valid | output | 1 | Recognized bit-field instruction |

## Verification
The bench builds the unit with the default 64-bit data width, which matches the 6-bit position field exactly. At this width the upper-half encodings (instr[0] = 1) reach every position from 32 to 63. Positions near the top of the word combined with lengths up to 32 produce the truncation cases of R5, and random instruction words also hit opcodes and function codes that the unit must reject.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned POS_W   = 6;
    localparam int unsigned LEN_W   = 6;
    localparam int unsigned REG_W   = 5;

    localparam logic [5:0] MAJOR_OPC = 6'b011100;
    localparam logic [4:0] FN_SEXT   = 5'b11101;
    localparam logic [4:0] FN_CINS   = 5'b11001;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SEXT = 2'd1,
        OP_CINS = 2'd2
    } bfx_op_e;

    typedef struct packed {
        bfx_op_e          op;
        logic [POS_W-1:0] pos;
        logic [LEN_W-1:0] len;
        logic [REG_W-1:0] dst;
    } bfx_dec_t;

    function automatic bfx_op_e classify(input logic [INSTR_W-1:0] iw);
        if (iw[31:26] != MAJOR_OPC) return OP_NONE;
        if (iw[5:1] == FN_SEXT)     return OP_SEXT;
        if (iw[5:1] == FN_CINS)     return OP_CINS;
        return OP_NONE;
    endfunction

    function automatic logic [POS_W-1:0] field_pos(input logic [INSTR_W-1:0] iw);
        return {iw[0], iw[10:6]};
    endfunction

    function automatic logic [LEN_W-1:0] field_len(input logic [INSTR_W-1:0] iw);
        return {1'b0, iw[15:11]} + LEN_W'(1);
    endfunction

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output bfx_dec_t           dec
);
    logic [4:0] unused_src_field;

    assign unused_src_field = instr[25:21];

    always_comb begin
        dec.op  = classify(instr);
        dec.pos = field_pos(instr);
        dec.len = field_len(instr);
        dec.dst = instr[20:16];
    end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] src,
    input  logic [POS_W-1:0]  pos,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] res
);
    localparam int unsigned CW = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] keep;
    logic [CW-1:0]     room;
    logic [CW-1:0]     width;
    logic [CW-1:0]     top_idx;
    logic              sign;

    assign shifted = src >> pos;
    assign room    = CW'(DATA_W) - CW'(pos);
    assign width   = (CW'(len) > room) ? room : CW'(len);
    assign top_idx = width - CW'(1);
    assign sign    = shifted[top_idx[CW-2:0]];

    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        assign keep[i] = (CW'(i) < width);
    end

    assign res = (shifted & keep) | ({DATA_W{sign}} & ~keep);
endmodule

// File: rtl/bfx_insert.sv
module bfx_insert
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] src,
    input  logic [POS_W-1:0]  pos,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] res
);
    localparam int unsigned CW = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] low_mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign low_mask[i] = (CW'(i) < CW'(len));
    end

    assign res = (src & low_mask) << pos;
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  rs_val,
    output logic [DATA_W-1:0]  result,
    output logic [REG_W-1:0]   dst_idx,
    output logic               wr_en,
    output logic               valid
);
    bfx_dec_t          dec;
    logic [DATA_W-1:0] ext_res;
    logic [DATA_W-1:0] ins_res;

    bfx_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    bfx_extract #(.DATA_W(DATA_W)) u_ext (
        .src (rs_val),
        .pos (dec.pos),
        .len (dec.len),
        .res (ext_res)
    );

    bfx_insert #(.DATA_W(DATA_W)) u_ins (
        .src (rs_val),
        .pos (dec.pos),
        .len (dec.len),
        .res (ins_res)
    );

    always_comb begin
        unique case (dec.op)
            OP_SEXT: result = ext_res;
            OP_CINS: result = ins_res;
            default: result = '0;
        endcase
    end

    assign valid   = (dec.op != OP_NONE);
    assign dst_idx = dec.dst;
    assign wr_en   = valid && (dec.dst != '0);
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  rs_val,
    input logic [DATA_W-1:0]  result,
    input logic [REG_W-1:0]   dst_idx,
    input logic               wr_en,
    input logic               valid
);
    logic [DATA_W-1:0] below_pos;
    logic              is_ins;
    logic              is_ext;
    logic              unused_rs;

    assign unused_rs = ^rs_val;
    assign is_ins    = (instr[31:26] == MAJOR_OPC) && (instr[5:1] == FN_CINS);
    assign is_ext    = (instr[31:26] == MAJOR_OPC) && (instr[5:1] == FN_SEXT);
    assign below_pos = (DATA_W'(1) << field_pos(instr)) - DATA_W'(1);

    always_comb begin
        p_wr_needs_valid_r6: assert (!wr_en || valid)
            else $error("wr_en without valid");
        p_zero_dst_nop_r6: assert (!(dst_idx == '0 && wr_en))
            else $error("write to index 0");
        p_dst_from_word_r6: assert (dst_idx == instr[20:16])
            else $error("dst_idx mismatch");
        p_reject_quiet_r7: assert (valid || (result == '0 && !wr_en))
            else $error("invalid encoding produced output");
        p_ins_low_clear_r2: assert (!(valid && is_ins) || ((result & below_pos) == '0))
            else $error("insert set bits below position");
        p_ext_sign_fill_r1: assert (!(valid && is_ext) ||
                                    (&result[DATA_W-1:31]) || !(|result[DATA_W-1:31]))
            else $error("extract upper bits not a sign fill");
    end
endmodule

bind bfx_unit bfx_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .instr   (instr),
    .rs_val  (rs_val),
    .result  (result),
    .dst_idx (dst_idx),
    .wr_en   (wr_en),
    .valid   (valid)
);

// File: tb/bfx_unit_tb.sv
module bfx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr;
    logic [63:0] rs_val;
    logic [63:0] result;
    logic [4:0]  dst_idx;
    logic        wr_en;
    logic        valid;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bfx_unit dut_i (
        .instr   (instr),
        .rs_val  (rs_val),
        .result  (result),
        .dst_idx (dst_idx),
        .wr_en   (wr_en),
        .valid   (valid)
    );

    function automatic logic [31:0] mk(input logic [4:0] fn, input logic [4:0] rt,
                                       input int pos, input int len);
        logic [5:0] p6;
        logic [4:0] lm;
        p6 = 6'(pos);
        lm = 5'(len - 1);
        return {6'b011100, 5'd3, rt, lm, p6[4:0], fn, p6[5]};
    endfunction

    function automatic logic [63:0] exp_ext(input logic [63:0] rs, input int pos, input int len);
        logic [63:0] r;
        logic        s;
        int          w;
        r = '0;
        s = 1'b0;
        w = (pos + len > 64) ? 64 - pos : len;
        for (int i = 0; i < w; i++) begin
            r[i] = rs[pos + i];
            s    = rs[pos + i];
        end
        for (int i = w; i < 64; i++) r[i] = s;
        return r;
    endfunction

    function automatic logic [63:0] exp_ins(input logic [63:0] rs, input int pos, input int len);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < len; i++)
            if (pos + i < 64) r[pos + i] = rs[i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] iw, input logic [63:0] rs);
        @(negedge clk);
        instr  = iw;
        rs_val = rs;
        #2;
    endtask

    task automatic check_all(input string req);
        logic        is_op;
        logic        is_ext;
        logic [63:0] er;
        int          p;
        int          l;
        is_op  = (instr[31:26] == 6'b011100) &&
                 (instr[5:1] == 5'b11101 || instr[5:1] == 5'b11001);
        is_ext = (instr[5:1] == 5'b11101);
        p      = {26'd0, instr[0], instr[10:6]};
        l      = int'(instr[15:11]) + 1;
        er     = !is_op ? 64'd0 : (is_ext ? exp_ext(rs_val, p, l) : exp_ins(rs_val, p, l));
        chk({req, " result"}, result, er);
        chk({req, " valid R7"}, 64'(valid), 64'(is_op));
        chk({req, " wr_en R6"}, 64'(wr_en), 64'(is_op && instr[20:16] != 5'd0));
        chk({req, " dst R6"}, 64'(dst_idx), 64'(instr[20:16]));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        instr  = 32'd0;
        rs_val = 64'd0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle word: rejected
        apply(32'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7 idle result", result, 64'd0);
        chk("R7 idle valid", 64'(valid), 64'd0);

        // R1 negative field at pos 4, len 8
        apply(mk(5'b11101, 5'd7, 4, 8), 64'h0000_0000_0000_0F80);
        chk("R1 neg extract", result, 64'hFFFF_FFFF_FFFF_FFF8);
        // R1 positive field
        apply(mk(5'b11101, 5'd7, 8, 12), 64'h0000_0000_0057_3400);
        chk("R1 pos extract", result, 64'h0000_0000_0000_0734);
        // R3 upper-half position 40, R4 length 8
        apply(mk(5'b11101, 5'd2, 40, 8), 64'h0000_8500_0000_0000);
        chk("R3 R4 hi extract", result, 64'hFFFF_FFFF_FFFF_FF85);
        // R5 extract past bit 63, sign from bit 63
        apply(mk(5'b11101, 5'd2, 60, 8), 64'hA000_0000_0000_0000);
        chk("R5 extract trunc", result, 64'hFFFF_FFFF_FFFF_FFFA);
        // R2 insert full 32 at pos 0
        apply(mk(5'b11001, 5'd9, 0, 32), 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R2 insert", result, 64'h0000_0000_FFFF_FFFF);
        // R4 length 1
        apply(mk(5'b11001, 5'd9, 17, 1), 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R4 len1 insert", result, 64'h0000_0000_0002_0000);
        // R5 insert truncation at pos 48, len 32
        apply(mk(5'b11001, 5'd9, 48, 32), 64'h1234_5678_9ABC_DEF1);
        chk("R5 insert trunc", result, 64'hDEF1_0000_0000_0000);
        // R6 destination 0 is no-op
        apply(mk(5'b11001, 5'd0, 4, 4), 64'hF);
        chk("R6 rt0 wr_en", 64'(wr_en), 64'd0);
        chk("R6 rt0 valid", 64'(valid), 64'd1);
        // R7 wrong opcode, wrong function
        apply(mk(5'b11101, 5'd5, 4, 4) ^ 32'h0400_0000, 64'hFF);
        check_all("R7 bad opcode");
        apply(mk(5'b11011, 5'd5, 4, 4), 64'hFF);
        check_all("R7 bad func");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] iw;
            logic [63:0] rs;
            int          sel;
            sel = int'($urandom_range(0, 4));
            rs  = {$urandom(), $urandom()};
            if (sel == 0)      iw = $urandom();
            else if (sel <= 2) iw = mk(5'b11101, 5'($urandom()), int'($urandom_range(0, 63)),
                                       int'($urandom_range(1, 32)));
            else               iw = mk(5'b11001, 5'($urandom()), int'($urandom_range(0, 63)),
                                       int'($urandom_range(1, 32)));
            apply(iw, rs);
            check_all("R1 R2 R3 R4 R5 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule